// File: doc/BRIEF.md
# Programmable Multi-State Trigger Sequencer

This block decides, one acquired sample per clock, when an acquisition engine fires its trigger, which samples it keeps and how it drives a general-purpose signal line. It holds a current state. Every state owns a small bank of if/then clauses. A clause tests a selected subset of event inputs, combined either as "any of" or "all of". The lowest-numbered clause that holds in the current state applies its whole set of actions in that cycle. The events are word and range recognizers on the sample, two counter/timer comparisons, the external, glitch and violation flags, a sample-changed flag and an always-true event. The actions are trigger, store control, counter and timer control, goto and signal set/clear.

Software fills the clause tables, recognizer values and limits through a simple write port, then pulses `arm_i`. Arming returns the sequencer to state 0, clears both counters, stops the timer and clears the trigger latch. After that the outputs follow the sample stream with one register stage of delay. The acquisition memory that consumes `store_o` lies outside this block.

Top module: `trigseq_top`

## Requirements
- R1: Reset and a one-cycle `arm_i` pulse both put the sequencer in state 0. They zero the event counter and the timer, stop the timer, close the store window and clear the trigger latch. In the cycle after arm, `trig_o`, `store_o` and `sig_o` are low. Reset also sets every configuration word to zero.
- R2: Configuration writes use `cfg_addr_i` bit 5 = 0 for clause words, with state in bits [4:3], clause in [2:1] and word select in [0]. Word 0 holds the event mask in bits [12:0] and the combine mode in bit 31 (1 = all masked events true, 0 = any masked event true). A clause whose mask is zero never holds. Event bits: 0-3 word recognizers, 4-5 range recognizers, 6 counter at limit, 7 timer at limit, 8 external, 9 glitch, 10 violation, 11 sample changed, 12 always true.
- R3: Clause word 1 holds the action set in bits [12:0] and the goto target in bits [19:16]. Action bits: 0 trigger, 1 store this sample, 2 do not store this sample, 3 open store window, 4 close store window, 5 count up, 6 zero counter, 7 start timer, 8 stop timer, 9 zero timer, 10 goto, 11 set signal, 12 clear signal. An empty action set does nothing. When several clauses of the current state hold, only the lowest-numbered one applies its actions.
- R4: Word recognizer k matches when (sample XOR value) AND mask is zero; its value is at address 0x20+2k and its mask at 0x21+2k. Range recognizer r matches when low <= sample <= high, inclusive; its low is at 0x30+2r and its high at 0x31+2r.
- R5: The counter rises by one per count-up action, and zeroing wins over counting. Its event holds while count >= limit (low 32 bits at 0x38, upper bits at 0x39). The event reflects the new count on the very next sample.
- R6: The timer advances once per clock while running, starting on the edge of the start action, so it reads j on the j-th sample after that action. Stop freezes it and zero clears it without stopping it. Its event holds while timer >= limit (0x3A low, 0x3B high).
- R7: A goto action moves to the target state for the next sample. A target at or above the state count is ignored, and without a goto the state holds.
- R8: `trig_o` pulses for one cycle on the first trigger action after arm. Later trigger actions are ignored until the next arm.
- R9: The store mode at 0x3C bits [1:0] selects 0 = every sample, 1 = window, 2 = action only, 3 = changed samples only. In window mode a sample is stored while the window is open; the opening sample is stored and the closing sample is not.
- R10: In action mode only samples with the store action are kept. In changed mode a sample is kept when it differs from the previous sample. In every mode the store action forces the sample to be kept and the do-not-store action suppresses it, with suppression winning.
- R11: `sig_o` is set by the set action and cleared by the clear action. When one clause does both, clear wins.
- R12: The external, glitch and violation inputs, the sample-changed flag and the always-true event are all usable in clause masks, under either combine mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Re-arm pulse: home state, clear counters and latches |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 6 | Configuration word address |
| cfg_wdata_i | input | 32 | Configuration write data |
| sample_i | input | 16 | Acquired sample, one per clock |
| ext_i | input | 1 | External signal event |
| glitch_i | input | 1 | Glitch flag for this sample |
| viol_i | input | 1 | Setup/hold violation flag for this sample |
| trig_o | output | 1 | One-cycle trigger pulse |
| store_o | output | 1 | Keep this sample |
| sig_o | output | 1 | Programmable signal output |

## Verification
A wrong state register shows up as the wrong clause bank answering. The signal or trigger output then moves on the sample after the faulty goto, so the bench reads state through `sig_o` set by clauses placed only in the target state. Counter and timer errors shift the trigger by whole samples, so the bench counts the exact sample on which `trig_o` rises after a known number of count or start actions. A broken priority or store-window latch changes `sig_o` or `store_o` on the very sample where two clauses overlap or the window opens or closes.

// File: rtl/trigseq_pkg.sv
package trigseq_pkg;
   localparam int ACT_W = 13;
   localparam int A_TRIG      = 0;
   localparam int A_STORE     = 1;
   localparam int A_NOSTORE   = 2;
   localparam int A_WIN_OPEN  = 3;
   localparam int A_WIN_CLOSE = 4;
   localparam int A_CNT_INC   = 5;
   localparam int A_CNT_CLR   = 6;
   localparam int A_TMR_GO    = 7;
   localparam int A_TMR_HALT  = 8;
   localparam int A_TMR_CLR   = 9;
   localparam int A_GOTO      = 10;
   localparam int A_SIG_SET   = 11;
   localparam int A_SIG_CLR   = 12;

   localparam int TGT_LSB = 16;
   localparam int AND_BIT = 31;

   typedef enum logic [1:0] {
      KEEP_ALL    = 2'd0,
      KEEP_WINDOW = 2'd1,
      KEEP_ACTION = 2'd2,
      KEEP_CHANGE = 2'd3
   } keep_mode_e;
endpackage

// File: rtl/trigseq_events.sv
module trigseq_events #(
   parameter int DATA_W  = 16,
   parameter int N_WORD  = 4,
   parameter int N_RANGE = 2,
   localparam int EV_W   = N_WORD + N_RANGE + 7
) (
   input  logic [DATA_W-1:0]               sample_i,
   input  logic [DATA_W-1:0]               prev_i,
   input  logic [N_WORD-1:0][DATA_W-1:0]   wval_i,
   input  logic [N_WORD-1:0][DATA_W-1:0]   wmsk_i,
   input  logic [N_RANGE-1:0][DATA_W-1:0]  rlo_i,
   input  logic [N_RANGE-1:0][DATA_W-1:0]  rhi_i,
   input  logic                            cnt_hit_i,
   input  logic                            tmr_hit_i,
   input  logic                            ext_i,
   input  logic                            glitch_i,
   input  logic                            viol_i,
   output logic [EV_W-1:0]                 ev_o
);
   localparam int E_CNT = N_WORD + N_RANGE;

   for (genvar k = 0; k < N_WORD; k++) begin : g_word
      assign ev_o[k] = ((sample_i ^ wval_i[k]) & wmsk_i[k]) == '0;
   end

   for (genvar r = 0; r < N_RANGE; r++) begin : g_range
      assign ev_o[N_WORD+r] = (sample_i >= rlo_i[r]) && (sample_i <= rhi_i[r]);
   end

   assign ev_o[E_CNT]   = cnt_hit_i;
   assign ev_o[E_CNT+1] = tmr_hit_i;
   assign ev_o[E_CNT+2] = ext_i;
   assign ev_o[E_CNT+3] = glitch_i;
   assign ev_o[E_CNT+4] = viol_i;
   assign ev_o[E_CNT+5] = (sample_i != prev_i);
   assign ev_o[E_CNT+6] = 1'b1;
endmodule

// File: rtl/trigseq_pick.sv
module trigseq_pick #(
   parameter int N_CL = 4,
   parameter int EV_W = 13
) (
   input  logic [EV_W-1:0]            ev_i,
   input  logic [N_CL-1:0][EV_W-1:0]  msk_i,
   input  logic [N_CL-1:0]            all_i,
   output logic [N_CL-1:0]            win_o
);
   logic [N_CL-1:0] hit;

   for (genvar c = 0; c < N_CL; c++) begin : g_cl
      assign hit[c] = (|msk_i[c]) &&
                      (all_i[c] ? (&(ev_i | ~msk_i[c])) : (|(ev_i & msk_i[c])));
   end

   // isolate the lowest set bit: lowest-numbered true clause wins
   assign win_o = hit & (~hit + 1'b1);
endmodule

// File: rtl/trigseq_ctr.sv
module trigseq_ctr #(
   parameter int W        = 51,
   parameter bit IS_TIMER = 1'b0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clear_i,
   input  logic         step_i,
   input  logic         halt_i,
   input  logic         zero_i,
   input  logic [W-1:0] limit_i,
   output logic         hit_o
);
   logic [W-1:0] val_q;

   assign hit_o = (val_q >= limit_i);

   if (IS_TIMER) begin : g_tmr
      logic run_q, run_eff;
      assign run_eff = (run_q | step_i) & ~halt_i;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            val_q <= '0;
            run_q <= 1'b0;
         end else if (clear_i) begin
            val_q <= '0;
            run_q <= 1'b0;
         end else begin
            run_q <= run_eff;
            if (zero_i)       val_q <= '0;
            else if (run_eff) val_q <= val_q + 1'b1;
         end
      end

      AST_TMR_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (run_q && !clear_i && !zero_i && !halt_i) |=> (val_q == $past(val_q) + 1'b1)); // R6
   end else begin : g_cnt
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                 val_q <= '0;
         else if (clear_i || zero_i)  val_q <= '0;
         else if (step_i && !halt_i)  val_q <= val_q + 1'b1;
      end

      AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!clear_i && !zero_i && !step_i) |=> $stable(val_q)); // R5
   end

   AST_CTR_ZEROED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clear_i || zero_i) |=> (val_q == '0)); // R1
endmodule

// File: rtl/trigseq_top.sv
module trigseq_top
   import trigseq_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int N_STATES  = 4,
   parameter int N_CLAUSES = 4,
   parameter int N_WORD    = 4,
   parameter int N_RANGE   = 2,
   parameter int CNT_W     = 51,
   parameter int ADDR_W    = 6
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              arm_i,
   input  logic              cfg_we_i,
   input  logic [ADDR_W-1:0] cfg_addr_i,
   input  logic [31:0]       cfg_wdata_i,
   input  logic [DATA_W-1:0] sample_i,
   input  logic              ext_i,
   input  logic              glitch_i,
   input  logic              viol_i,
   output logic              trig_o,
   output logic              store_o,
   output logic              sig_o
);
   localparam int SW   = $clog2(N_STATES);
   localparam int CW   = $clog2(N_CLAUSES);
   localparam int EV_W = N_WORD + N_RANGE + 7;

   if (N_STATES < 2 || N_STATES > 16)       begin : g_bad_st  $error("N_STATES out of 2..16");    end
   if (N_CLAUSES < 2 || N_CLAUSES > 16)     begin : g_bad_cl  $error("N_CLAUSES out of 2..16");   end
   if (N_WORD < 1 || N_WORD > 8)            begin : g_bad_w   $error("N_WORD out of 1..8");       end
   if (N_RANGE < 1 || N_RANGE > 4)          begin : g_bad_r   $error("N_RANGE out of 1..4");      end
   if (DATA_W < 1 || DATA_W > 32)           begin : g_bad_d   $error("DATA_W out of 1..32");      end
   if (CNT_W < 33 || CNT_W > 64)            begin : g_bad_c   $error("CNT_W out of 33..64");      end
   if (EV_W > AND_BIT)                      begin : g_bad_e   $error("event vector too wide");   end
   if (ADDR_W - 1 < SW + CW + 1 || ADDR_W < 6) begin : g_bad_a $error("ADDR_W too small");       end

   // ---------------- configuration storage ----------------
   logic [EV_W-1:0]  cl_msk [N_STATES][N_CLAUSES];
   logic             cl_all [N_STATES][N_CLAUSES];
   logic [ACT_W-1:0] cl_act [N_STATES][N_CLAUSES];
   logic [3:0]       cl_tgt [N_STATES][N_CLAUSES];
   logic [N_WORD-1:0][DATA_W-1:0]  wval, wmsk;
   logic [N_RANGE-1:0][DATA_W-1:0] rlo, rhi;
   logic [CNT_W-1:0] cnt_lim, tmr_lim;
   keep_mode_e       keep_mode;

   logic          in_misc;
   logic [SW-1:0] wa_st;
   logic [CW-1:0] wa_cl;
   logic [4:0]    wa_m;
   assign in_misc = cfg_addr_i[ADDR_W-1];
   assign wa_st   = cfg_addr_i[SW+CW:CW+1];
   assign wa_cl   = cfg_addr_i[CW:1];
   assign wa_m    = cfg_addr_i[4:0];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int s = 0; s < N_STATES; s++) begin
            for (int c = 0; c < N_CLAUSES; c++) begin
               cl_msk[s][c] <= '0;
               cl_all[s][c] <= 1'b0;
               cl_act[s][c] <= '0;
               cl_tgt[s][c] <= '0;
            end
         end
         wval      <= '0;
         wmsk      <= '0;
         rlo       <= '0;
         rhi       <= '0;
         cnt_lim   <= '0;
         tmr_lim   <= '0;
         keep_mode <= KEEP_ALL;
      end else if (cfg_we_i) begin
         if (!in_misc) begin
            if (!cfg_addr_i[0]) begin
               cl_msk[wa_st][wa_cl] <= cfg_wdata_i[EV_W-1:0];
               cl_all[wa_st][wa_cl] <= cfg_wdata_i[AND_BIT];
            end else begin
               cl_act[wa_st][wa_cl] <= cfg_wdata_i[ACT_W-1:0];
               cl_tgt[wa_st][wa_cl] <= cfg_wdata_i[TGT_LSB+3:TGT_LSB];
            end
         end else begin
            for (int k = 0; k < N_WORD; k++) begin
               if (wa_m == 5'(2*k))   wval[k] <= cfg_wdata_i[DATA_W-1:0];
               if (wa_m == 5'(2*k+1)) wmsk[k] <= cfg_wdata_i[DATA_W-1:0];
            end
            for (int r = 0; r < N_RANGE; r++) begin
               if (wa_m == 5'(16+2*r)) rlo[r] <= cfg_wdata_i[DATA_W-1:0];
               if (wa_m == 5'(17+2*r)) rhi[r] <= cfg_wdata_i[DATA_W-1:0];
            end
            case (wa_m)
               5'h18:   cnt_lim[31:0]       <= cfg_wdata_i;
               5'h19:   cnt_lim[CNT_W-1:32] <= cfg_wdata_i[CNT_W-33:0];
               5'h1A:   tmr_lim[31:0]       <= cfg_wdata_i;
               5'h1B:   tmr_lim[CNT_W-1:32] <= cfg_wdata_i[CNT_W-33:0];
               5'h1C:   keep_mode           <= keep_mode_e'(cfg_wdata_i[1:0]);
               default: ;
            endcase
         end
      end
   end

   // ---------------- evaluation ----------------
   logic [SW-1:0]                    state_q;
   logic                             trig_done_q, win_q;
   logic [DATA_W-1:0]                prev_q;
   logic                             cnt_hit, tmr_hit;
   logic [EV_W-1:0]                  ev;
   logic [N_CLAUSES-1:0][EV_W-1:0]   cur_msk;
   logic [N_CLAUSES-1:0]             cur_all, win;
   logic [CW-1:0]                    win_idx;
   logic [ACT_W-1:0]                 act;
   logic [3:0]                       tgt;
   logic                             goto_ok, win_nx, keep_base;

   trigseq_events #(.DATA_W(DATA_W), .N_WORD(N_WORD), .N_RANGE(N_RANGE)) u_ev (
      .sample_i (sample_i), .prev_i (prev_q),
      .wval_i (wval), .wmsk_i (wmsk), .rlo_i (rlo), .rhi_i (rhi),
      .cnt_hit_i (cnt_hit), .tmr_hit_i (tmr_hit),
      .ext_i (ext_i), .glitch_i (glitch_i), .viol_i (viol_i),
      .ev_o (ev)
   );

   always_comb begin
      for (int c = 0; c < N_CLAUSES; c++) begin
         cur_msk[c] = cl_msk[state_q][c];
         cur_all[c] = cl_all[state_q][c];
      end
   end

   trigseq_pick #(.N_CL(N_CLAUSES), .EV_W(EV_W)) u_pick (
      .ev_i (ev), .msk_i (cur_msk), .all_i (cur_all), .win_o (win)
   );

   always_comb begin
      win_idx = '0;
      for (int c = 0; c < N_CLAUSES; c++) begin
         if (win[c]) win_idx = CW'(c);
      end
   end

   assign act     = (|win) ? cl_act[state_q][win_idx] : '0;
   assign tgt     = cl_tgt[state_q][win_idx];
   assign goto_ok = act[A_GOTO] && (int'(tgt) < N_STATES);
   assign win_nx  = act[A_WIN_CLOSE] ? 1'b0 : (win_q | act[A_WIN_OPEN]);

   always_comb begin
      case (keep_mode)
         KEEP_ALL:    keep_base = 1'b1;
         KEEP_WINDOW: keep_base = win_nx;
         KEEP_ACTION: keep_base = 1'b0;
         default:     keep_base = (sample_i != prev_q);
      endcase
   end

   trigseq_ctr #(.W(CNT_W), .IS_TIMER(1'b0)) u_cnt (
      .clk_i (clk_i), .rst_ni (rst_ni), .clear_i (arm_i),
      .step_i (act[A_CNT_INC]), .halt_i (1'b0), .zero_i (act[A_CNT_CLR]),
      .limit_i (cnt_lim), .hit_o (cnt_hit)
   );

   trigseq_ctr #(.W(CNT_W), .IS_TIMER(1'b1)) u_tmr (
      .clk_i (clk_i), .rst_ni (rst_ni), .clear_i (arm_i),
      .step_i (act[A_TMR_GO]), .halt_i (act[A_TMR_HALT]), .zero_i (act[A_TMR_CLR]),
      .limit_i (tmr_lim), .hit_o (tmr_hit)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q     <= '0;
         trig_done_q <= 1'b0;
         win_q       <= 1'b0;
         prev_q      <= '0;
         trig_o      <= 1'b0;
         store_o     <= 1'b0;
         sig_o       <= 1'b0;
      end else begin
         prev_q <= sample_i;
         if (arm_i) begin
            state_q     <= '0;
            trig_done_q <= 1'b0;
            win_q       <= 1'b0;
            trig_o      <= 1'b0;
            store_o     <= 1'b0;
            sig_o       <= 1'b0;
         end else begin
            if (goto_ok) state_q <= tgt[SW-1:0];
            trig_o <= act[A_TRIG] & ~trig_done_q;
            if (act[A_TRIG]) trig_done_q <= 1'b1;
            win_q   <= win_nx;
            store_o <= (keep_base | act[A_STORE]) & ~act[A_NOSTORE];
            if (act[A_SIG_CLR])      sig_o <= 1'b0;
            else if (act[A_SIG_SET]) sig_o <= 1'b1;
         end
      end
   end

   // ---------------- assertions ----------------
   AST_ARM_HOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
      arm_i |=> (state_q == '0 && !trig_o && !store_o && !sig_o)); // R1
   AST_ONE_WINNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(win)); // R3
   AST_STATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!arm_i && !act[A_GOTO]) |=> $stable(state_q)); // R7
   AST_TRIG_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig_o |=> !trig_o); // R8
   AST_NOSTORE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!arm_i && act[A_NOSTORE]) |=> !store_o); // R10
   AST_SIG_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!arm_i && act[A_SIG_CLR]) |=> !sig_o); // R11
endmodule

// File: tb/tb_trigseq_top.sv
module tb_trigseq_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        arm = 1'b0;
   logic        cfg_we = 1'b0;
   logic [5:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [15:0] sample = '0;
   logic        ext = 1'b0, glitch = 1'b0, viol = 1'b0;
   logic        trig_o, store_o, sig_o;
   int          n_chk = 0, n_bad = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   trigseq_top dut (
      .clk_i (clk), .rst_ni (rst_n), .arm_i (arm),
      .cfg_we_i (cfg_we), .cfg_addr_i (cfg_addr), .cfg_wdata_i (cfg_wdata),
      .sample_i (sample), .ext_i (ext), .glitch_i (glitch), .viol_i (viol),
      .trig_o (trig_o), .store_o (store_o), .sig_o (sig_o)
   );

   // event mask bits
   localparam logic [12:0] M_W0  = 13'h0001, M_R0 = 13'h0010, M_CNT = 13'h0040,
                           M_TMR = 13'h0080, M_EXT = 13'h0100, M_GL = 13'h0200,
                           M_VI  = 13'h0400, M_CHG = 13'h0800, M_ANY = 13'h1000;
   // action bits
   localparam logic [12:0] X_TRIG = 13'h0001, X_STORE = 13'h0002, X_NOST = 13'h0004,
                           X_OPEN = 13'h0008, X_CLOSE = 13'h0010, X_INC = 13'h0020,
                           X_CCLR = 13'h0040, X_GO = 13'h0080, X_HALT = 13'h0100,
                           X_TCLR = 13'h0200, X_GOTO = 13'h0400, X_SET = 13'h0800,
                           X_SCLR = 13'h1000;

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic clause(input int st, input int cl, input logic all_m,
                         input logic [12:0] msk, input logic [12:0] a, input int tg);
      wr(6'(st*8 + cl*2),     {all_m, 18'd0, msk});
      wr(6'(st*8 + cl*2 + 1), {12'd0, 4'(tg), 3'd0, a});
   endtask

   task automatic do_arm();
      @(negedge clk); arm = 1'b1;
      @(posedge clk); #1; arm = 1'b0;
   endtask

   task automatic step(input logic [15:0] s, input logic e = 1'b0,
                       input logic g = 1'b0, input logic v = 1'b0);
      @(negedge clk);
      sample = s; ext = e; glitch = g; viol = v;
      @(posedge clk); #1;
      ext = 1'b0; glitch = 1'b0; viol = 1'b0;
   endtask

   task automatic wipe();
      for (int s = 0; s < 4; s++)
         for (int c = 0; c < 4; c++) clause(s, c, 1'b0, '0, '0, 0);
      wr(6'h3C, 32'd0);
   endtask

   task automatic t_reset();
      step(16'h0);
      chk("R1 trig after reset", trig_o, 0);
      chk("R1 sig after reset", sig_o, 0);
      chk("R9 keep-all after reset", store_o, 1);
   endtask

   task automatic t_count();
      wipe();
      wr(6'h20, 32'hAA00); wr(6'h21, 32'hFF00);
      wr(6'h38, 32'd3);    wr(6'h39, 32'd0);
      clause(0, 0, 1'b0, M_W0,  X_INC, 0);
      clause(0, 1, 1'b0, M_CNT, X_TRIG | X_GOTO, 1);
      clause(1, 0, 1'b0, M_ANY, X_TRIG | X_SET, 0);
      do_arm();
      step(16'hAA01); chk("R4 word match count 1", trig_o, 0);
      step(16'hAA02); chk("R5 count 2", trig_o, 0);
      step(16'h1234); chk("R4 word mismatch", trig_o, 0);
      step(16'hAAFF); chk("R5 count 3", trig_o, 0);
      step(16'h0000); chk("R5 count at limit fires", trig_o, 1);
      step(16'h0000); chk("R8 second trigger ignored", trig_o, 0);
      chk("R7 goto reached state 1", sig_o, 1);
      do_arm();
      chk("R1 sig after arm", sig_o, 0);
      step(16'h0000); chk("R1 counter zero after arm", trig_o, 0);
      step(16'hAA00); step(16'hAA00); step(16'hAA00);
      chk("R1 state 0 after arm", sig_o, 0);
      step(16'h0000); chk("R8 re-armed trigger", trig_o, 1);
   endtask

   task automatic t_counter_clear();
      wipe();
      wr(6'h38, 32'd2); wr(6'h39, 32'd0);
      clause(0, 0, 1'b0, M_EXT, X_INC, 0);
      clause(0, 1, 1'b0, M_VI,  X_CCLR, 0);
      clause(0, 2, 1'b0, M_CNT, X_SET, 0);
      do_arm();
      step(16'h0, 1'b1);
      step(16'h0, 1'b0, 1'b0, 1'b1);
      step(16'h0, 1'b1);
      step(16'h0); chk("R5 zeroed counter below limit", sig_o, 0);
      step(16'h0, 1'b1);
      step(16'h0); chk("R5 counter reaches limit", sig_o, 1);
   endtask

   task automatic t_priority();
      wipe();
      clause(0, 0, 1'b0, M_EXT, X_SET, 0);
      clause(0, 1, 1'b0, M_ANY, X_SCLR | X_TRIG, 0);
      do_arm();
      step(16'h0, 1'b1);
      chk("R3 lowest clause wins sig", sig_o, 1);
      chk("R3 loser actions not applied", trig_o, 0);
      step(16'h0);
      chk("R12 any event clause clears", sig_o, 0);
      chk("R3 next clause trigger", trig_o, 1);
   endtask

   task automatic t_combine();
      wipe();
      clause(0, 0, 1'b1, M_GL | M_VI, X_SET, 0);
      clause(0, 1, 1'b0, '0,          X_TRIG, 0);
      clause(0, 2, 1'b0, M_GL | M_VI, X_SCLR, 0);
      do_arm();
      step(16'h0, 1'b0, 1'b1, 1'b1); chk("R2 all-of holds", sig_o, 1);
      step(16'h0, 1'b0, 1'b1, 1'b0); chk("R2 all-of fails, any-of glitch", sig_o, 0);
      step(16'h0, 1'b0, 1'b1, 1'b1);
      step(16'h0, 1'b0, 1'b0, 1'b1); chk("R12 violation any-of", sig_o, 0);
      step(16'h0, 1'b0, 1'b1, 1'b1);
      step(16'h0);
      chk("R2 idle keeps sig", sig_o, 1);
      chk("R2 empty mask never fires", trig_o, 0);
   endtask

   task automatic t_range();
      wipe();
      wr(6'h30, 32'h0100); wr(6'h31, 32'h01FF);
      clause(0, 0, 1'b0, M_R0,  X_SET, 0);
      clause(0, 1, 1'b0, M_ANY, X_SCLR, 0);
      do_arm();
      step(16'h00FF); chk("R4 below range", sig_o, 0);
      step(16'h0100); chk("R4 low bound inclusive", sig_o, 1);
      step(16'h01FF); chk("R4 high bound inclusive", sig_o, 1);
      step(16'h0200); chk("R4 above range", sig_o, 0);
   endtask

   task automatic t_timer();
      wipe();
      wr(6'h3A, 32'd3); wr(6'h3B, 32'd0);
      clause(0, 0, 1'b0, M_EXT, X_GO | X_GOTO, 1);
      clause(1, 0, 1'b0, M_TMR, X_TRIG, 0);
      clause(1, 1, 1'b0, M_GL,  X_HALT, 0);
      clause(1, 2, 1'b0, M_VI,  X_TCLR, 0);
      do_arm();
      step(16'h0, 1'b1); chk("R6 start", trig_o, 0);
      step(16'h0); chk("R6 timer 1", trig_o, 0);
      step(16'h0); chk("R6 timer 2", trig_o, 0);
      step(16'h0); chk("R6 timer 3 fires", trig_o, 1);
      do_arm();
      step(16'h0, 1'b1);
      step(16'h0, 1'b0, 1'b1);
      for (int i = 0; i < 4; i++) begin
         step(16'h0); chk("R6 halted timer frozen", trig_o, 0);
      end
      do_arm();
      step(16'h0, 1'b1);
      step(16'h0);
      step(16'h0, 1'b0, 1'b0, 1'b1);
      for (int i = 0; i < 3; i++) begin
         step(16'h0); chk("R6 zeroed timer restarts", trig_o, 0);
      end
      step(16'h0); chk("R6 zeroed timer reaches limit", trig_o, 1);
   endtask

   task automatic t_store();
      wipe();
      wr(6'h3C, 32'd1);
      clause(0, 0, 1'b0, M_EXT, X_OPEN, 0);
      clause(0, 1, 1'b0, M_VI,  X_CLOSE, 0);
      do_arm();
      step(16'h0); chk("R9 window closed", store_o, 0);
      step(16'h0, 1'b1); chk("R9 opening sample kept", store_o, 1);
      step(16'h0); chk("R9 window open", store_o, 1);
      step(16'h0, 1'b0, 1'b0, 1'b1); chk("R9 closing sample dropped", store_o, 0);
      step(16'h0); chk("R9 window closed again", store_o, 0);

      wipe();
      wr(6'h3C, 32'd2);
      clause(0, 0, 1'b0, M_EXT, X_STORE, 0);
      do_arm();
      step(16'h0); chk("R10 action mode idle", store_o, 0);
      step(16'h0, 1'b1); chk("R10 store action", store_o, 1);

      wr(6'h3C, 32'd3);
      step(16'h0005); step(16'h0005); chk("R10 unchanged dropped", store_o, 0);
      step(16'h0006); chk("R10 changed kept", store_o, 1);
      step(16'h0006); chk("R10 unchanged again", store_o, 0);

      wipe();
      clause(0, 0, 1'b0, M_EXT, X_NOST, 0);
      do_arm();
      step(16'h0); chk("R9 keep all", store_o, 1);
      step(16'h0, 1'b1); chk("R10 do-not-store suppresses", store_o, 0);
   endtask

   task automatic t_signal();
      wipe();
      clause(0, 0, 1'b0, M_CHG, X_SET, 0);
      clause(0, 1, 1'b0, M_GL,  X_SET | X_SCLR, 0);
      clause(0, 2, 1'b0, M_ANY, X_SCLR, 0);
      do_arm();
      step(16'h0007); step(16'h0007); chk("R12 no change", sig_o, 0);
      step(16'h0008); chk("R12 change event", sig_o, 1);
      step(16'h0008, 1'b0, 1'b1); chk("R11 clear beats set", sig_o, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_count();
      t_counter_clear();
      t_priority();
      t_combine();
      t_range();
      t_timer();
      t_store();
      t_signal();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule